// File: doc/BRIEF.md
# Remote framebuffer bus bridge

This block lets a host processor drive up to two external display controllers over a shared 16-bit parallel panel bus. Each controller has its own chip-select strobe. The host writes 32-bit registers. A command or parameter write becomes one 16-bit panel write. A pixel-data write becomes two panel writes, with the low half sent first. A write to either of the two access registers performs a single panel read, and the returned half-word is captured in a receive buffer.

Next to the bus traffic, the bridge keeps a pixel countdown. Every data, read or status access takes one from the count. A guarded start command marks a transfer as busy. When the countdown reaches zero during a transfer, busy clears and a one-cycle frame-done pulse is sent to the display controller's interrupt logic. The per-chip configuration, on/off time, cycle time and data-cycle registers are storage only: nothing in this block times the bus from them.

Top module: `rfb_bridge`

## Requirements
- R1: After reset, the following reads hold. Control (offset 0x0C) reads 0x2. Both config registers (offsets 0x30 and 0x48) read 0x00310000. System status (0x08) reads 0x1, where bit 0 is reset-done and bit 8 is busy. Pixel count (0x10), line number (0x14), sync widths (0x60, 0x64) and all timing and data-cycle registers read 0.
- R2: Writes keep only the listed bits, and read-back shows exactly those bits:
  - control keeps bits 3:0, where bit 0 is enable, bit 1 is bypass, bit 2 selects chip 0 and bit 3 selects chip 1;
  - config keeps 0x003F1FFF;
  - on/off time (bank offset +4) keeps 0x3FFFFFFF;
  - cycle time (+8) keeps 0x0FFFFFFF;
  - data-cycle registers (+0xC, +0x10, +0x14) keep 0x0F1F0F1F;
  - line number keeps 11 bits;
  - the sync widths keep 16 bits;
  - idle mode (sysconfig, 0x04) keeps 0x19.

  Chip 0's bank starts at 0x30 and chip 1's bank starts at 0x48.
- R3: A write to the command register (0x18) puts the low 16 bits on the panel data bus with register-select 0 in the next cycle. A write to the parameter register (0x1C) does the same with register-select 1. Every chip selected in control bits 3:2 gets a one-cycle strobe.
- R4: A write to the data register (0x20) sends the low half in the next cycle and the high half in the cycle after. Both halves use register-select 1 and strobe the selected chips. The host ready signal is low for exactly the cycle in which the high half is pending, and a host write offered during that cycle is not taken.
- R5: A write to the read-access register (0x24, register-select 1) or the status-access register (0x28, register-select 0) performs a panel read. The read strobes only chip 0 if chip 0 is selected, and otherwise only chip 1, with the read indicator high. The panel read data in that strobe cycle is captured into the receive buffer, and reading 0x24 or 0x28 returns it.
- R6: Each data, read-access or status-access write takes one from the pixel count (0x10). Taking one from a zero count gives all ones.
- R7: A control write with bit 4 set starts a transfer and raises busy only when all of the following hold in the written value and the current state:
  - the new enable bit is 1;
  - the new bypass bit is 0;
  - the display-mode input is high;
  - the bridge is not already busy;
  - the bitwise AND of the two config registers with 0xC is zero.

  Any other start request is ignored.
- R8: When a counting access takes the count from 1 to 0 while busy, busy clears and frame_done is high for exactly one cycle. No pulse occurs while the bridge is not busy.
- R9: A sysconfig write with bit 1 set returns every register named in R1 to its reset value and clears busy. The same write stores its idle-mode bits.
- R10: When neither chip is selected, command, parameter, data and access writes produce no strobe and no read indicator. Data and access writes still count down the pixel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write request, taken when host_ready is high |
| host_addr | input | ADDR_W | Host byte address of the register |
| host_wdata | input | 2*BUS_W | Host write data |
| host_ready | output | 1 | Low while the high half of a data write is pending |
| host_rdata | output | 2*BUS_W | Read data for host_addr (combinational) |
| rfb_mode | input | 1 | Display controller has selected remote framebuffer output |
| pnl_data | output | BUS_W | Panel data bus |
| pnl_rs | output | 1 | Register select: 0 command/status, 1 data/parameter |
| pnl_cs | output | N_CHIP | One-cycle chip-select strobes |
| pnl_rd | output | 1 | High in the strobe cycle of a panel read |
| pnl_rdata | input | BUS_W | Panel read data |
| frame_done | output | 1 | One-cycle transfer-complete pulse |

## Verification
The bench goes after the two-cycle split of a data write. A design that lets a host write slip in during the stall would overwrite the high half with a command and send register-select 0. It also checks read-chip priority with both chips selected. A design that gets this wrong strobes both chips or captures chip 1's value. The countdown is driven through 1→0 both while busy and while idle, and then wraps from zero. This exposes a frame-done pulse outside a transfer or a count that saturates. Each start guard is tried alone, so a start that ignores bypass, the mode input or the config mask shows up as a set busy bit.

// File: rtl/rfb_pkg.sv
// Shared constants and types for the remote framebuffer bridge.
// Assumes a byte-addressed 32-bit register window and exactly two panel chips.
package rfb_pkg;

    localparam int N_CHIP = 2;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFS_SYSCFG  = 8'h04;
    localparam logic [7:0] OFS_SYSSTAT = 8'h08;
    localparam logic [7:0] OFS_CTRL    = 8'h0C;
    localparam logic [7:0] OFS_PIXCNT  = 8'h10;
    localparam logic [7:0] OFS_LINE    = 8'h14;
    localparam logic [7:0] OFS_CMD     = 8'h18;
    localparam logic [7:0] OFS_PARAM   = 8'h1C;
    localparam logic [7:0] OFS_DATA    = 8'h20;
    localparam logic [7:0] OFS_RDACC   = 8'h24;
    localparam logic [7:0] OFS_STACC   = 8'h28;
    localparam logic [7:0] OFS_BANK0   = 8'h30;
    localparam int         BANK_STRIDE = 24;
    localparam logic [7:0] OFS_VSW     = 8'h60;
    localparam logic [7:0] OFS_HSW     = 8'h64;

    // Write masks and reset values
    localparam logic [31:0] MSK_CFG    = 32'h003F_1FFF;
    localparam logic [31:0] MSK_ONOFF  = 32'h3FFF_FFFF;
    localparam logic [31:0] MSK_CYC    = 32'h0FFF_FFFF;
    localparam logic [31:0] MSK_DCYC   = 32'h0F1F_0F1F;
    localparam logic [4:0]  MSK_IDLE   = 5'h19;
    localparam logic [31:0] RST_CFG    = 32'h0031_0000;
    localparam logic [3:0]  RST_CTRL   = 4'h2;
    localparam logic [31:0] START_BLK  = 32'h0000_000C;

    // Control bit positions
    localparam int CB_EN   = 0;
    localparam int CB_BYP  = 1;
    localparam int CB_CS0  = 2;
    localparam int CB_GO   = 4;
    localparam int SB_BUSY = 8;

    // Kind of host access that reaches the panel sequencer
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CMD,
        ACC_PARAM,
        ACC_DATA,
        ACC_RDREG,
        ACC_STREG
    } acc_e;

endpackage

// File: rtl/rfb_chip_bank.sv
// Per-chip storage bank: config, on/off time, cycle time and three data-cycle
// registers, laid out at BASE, BASE+4 ... BASE+0x14. The registers are
// storage only. The config value is exported for the start guard.
// Assumes the host data width is 32 bits.
module rfb_chip_bank
    import rfb_pkg::*;
#(
    parameter int              AW    = 8,
    parameter int              DW    = 32,
    parameter logic [AW-1:0]   BASE  = '0,
    parameter int              N_DC  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          rd_hit,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] cfg_q
);

    localparam logic [AW-1:0] A_CFG   = BASE;
    localparam logic [AW-1:0] A_ONOFF = BASE + AW'(4);
    localparam logic [AW-1:0] A_CYC   = BASE + AW'(8);
    localparam logic [AW-1:0] A_DC0   = BASE + AW'(12);

    logic [DW-1:0] onoff_q;
    logic [DW-1:0] cyc_q;
    logic [DW-1:0] dc_q [N_DC];

    // Register updates with per-field write masks
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cfg_q   <= DW'(RST_CFG);
            onoff_q <= '0;
            cyc_q   <= '0;
            for (int k = 0; k < N_DC; k++) dc_q[k] <= '0;
        end else if (wr_en) begin
            if (addr == A_CFG)   cfg_q   <= wdata & DW'(MSK_CFG);
            if (addr == A_ONOFF) onoff_q <= wdata & DW'(MSK_ONOFF);
            if (addr == A_CYC)   cyc_q   <= wdata & DW'(MSK_CYC);
            for (int k = 0; k < N_DC; k++) begin
                if (addr == A_DC0 + AW'(4 * k)) dc_q[k] <= wdata & DW'(MSK_DCYC);
            end
        end
    end

    // Read decode for this bank
    always_comb begin
        rd_hit  = 1'b0;
        rd_data = '0;
        if (addr == A_CFG)   begin rd_hit = 1'b1; rd_data = cfg_q;   end
        if (addr == A_ONOFF) begin rd_hit = 1'b1; rd_data = onoff_q; end
        if (addr == A_CYC)   begin rd_hit = 1'b1; rd_data = cyc_q;   end
        for (int k = 0; k < N_DC; k++) begin
            if (addr == A_DC0 + AW'(4 * k)) begin
                rd_hit  = 1'b1;
                rd_data = dc_q[k];
            end
        end
    end

endmodule

// File: rtl/rfb_bus_seq.sv
// Panel bus sequencer: turns accepted host accesses into one-cycle strobes on
// the 16-bit panel bus, splits data writes into two halves (low first), and
// captures panel read data one cycle after a read strobe.
// Assumes the host is stalled (via hi_pend) while the high half is pending.
module rfb_bus_seq
    import rfb_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int NCH   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_e             acc,
    input  logic [2*BUS_W-1:0] wdata,
    input  logic [NCH-1:0]   chip_sel,
    input  logic [BUS_W-1:0] pnl_rdata,
    output logic [BUS_W-1:0] pnl_data,
    output logic             pnl_rs,
    output logic [NCH-1:0]   pnl_cs,
    output logic             pnl_rd,
    output logic             hi_pend,
    output logic [BUS_W-1:0] rxbuf
);

    logic [BUS_W-1:0] hi_hold;
    logic [NCH-1:0]   hi_cs;
    logic             cap_pend;
    logic [NCH-1:0]   rd_sel;

    // Pick the lowest-numbered selected chip for reads
    always_comb begin
        rd_sel = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (chip_sel[i]) rd_sel = NCH'(1) << i;
        end
    end

    // Panel strobe generation, half-word split and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pnl_data <= '0;
            pnl_rs   <= 1'b0;
            pnl_cs   <= '0;
            pnl_rd   <= 1'b0;
            hi_pend  <= 1'b0;
            hi_hold  <= '0;
            hi_cs    <= '0;
            cap_pend <= 1'b0;
            rxbuf    <= '0;
        end else begin
            pnl_cs   <= '0;
            pnl_rd   <= 1'b0;
            cap_pend <= 1'b0;
            if (cap_pend) rxbuf <= pnl_rdata;
            if (hi_pend) begin
                pnl_data <= hi_hold;
                pnl_rs   <= 1'b1;
                pnl_cs   <= hi_cs;
                hi_pend  <= 1'b0;
            end else begin
                case (acc)
                    ACC_CMD, ACC_PARAM: begin
                        pnl_data <= wdata[BUS_W-1:0];
                        pnl_rs   <= (acc == ACC_PARAM);
                        pnl_cs   <= chip_sel;
                    end
                    ACC_DATA: begin
                        pnl_data <= wdata[BUS_W-1:0];
                        pnl_rs   <= 1'b1;
                        pnl_cs   <= chip_sel;
                        hi_hold  <= wdata[2*BUS_W-1:BUS_W];
                        hi_cs    <= chip_sel;
                        hi_pend  <= 1'b1;
                    end
                    ACC_RDREG, ACC_STREG: begin
                        pnl_rs   <= (acc == ACC_RDREG);
                        pnl_cs   <= rd_sel;
                        pnl_rd   <= |rd_sel;
                        cap_pend <= |rd_sel;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rfb_xfer_ctl.sv
// Transfer control: pixel countdown, busy flag and frame-done pulse.
// Busy ends, with a one-cycle pulse, when a countdown step takes the count
// from 1 to 0. Counting from zero wraps. Load and step never coincide.
module rfb_xfer_ctl #(
    parameter int PIX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ld,
    input  logic [PIX_W-1:0] ld_val,
    input  logic             step,
    input  logic             start,
    output logic [PIX_W-1:0] cnt,
    output logic             busy,
    output logic             frame_done
);

    // Countdown, busy tracking and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cnt        <= '0;
            busy       <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (ld) begin
                cnt <= ld_val;
            end else if (step) begin
                cnt <= cnt - PIX_W'(1);
                if (busy && cnt == PIX_W'(1)) begin
                    busy       <= 1'b0;
                    frame_done <= 1'b1;
                end
            end
            if (start) busy <= 1'b1;
        end
    end

endmodule

// File: rtl/rfb_bridge.sv
// Remote framebuffer bus bridge top. It decodes host register writes,
// holds the control, idle, line and sync-width fields, and applies the start
// guard. It builds host read data and connects the per-chip banks, the panel
// sequencer and the transfer controller.
// Assumes host_rdata is sampled combinationally for the presented address.
module rfb_bridge
    import rfb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 16,
    parameter int PIX_W  = 32,
    parameter int LINE_W = 11,
    parameter int SYNC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [2*BUS_W-1:0]   host_wdata,
    output logic                 host_ready,
    output logic [2*BUS_W-1:0]   host_rdata,
    input  logic                 rfb_mode,
    output logic [BUS_W-1:0]     pnl_data,
    output logic                 pnl_rs,
    output logic [N_CHIP-1:0]    pnl_cs,
    output logic                 pnl_rd,
    input  logic [BUS_W-1:0]     pnl_rdata,
    output logic                 frame_done
);

    localparam int HW = 2 * BUS_W;

    logic              wr_ok;
    logic              soft_rst;
    logic              start;
    logic              step;
    acc_e              acc;
    logic [3:0]        ctrl_q;
    logic [4:0]        idle_q;
    logic [LINE_W-1:0] line_q;
    logic [SYNC_W-1:0] vsw_q;
    logic [SYNC_W-1:0] hsw_q;
    logic [PIX_W-1:0]  pix_cnt;
    logic              busy;
    logic              hi_pend;
    logic [BUS_W-1:0]  rxbuf;
    logic [HW-1:0]     cfg_q   [N_CHIP];
    logic [HW-1:0]     bank_rd [N_CHIP];
    logic [N_CHIP-1:0] bank_hit;
    logic [HW-1:0]     cfg_and;

    assign host_ready = !hi_pend;
    assign wr_ok      = host_wr && host_ready;
    assign soft_rst   = wr_ok && host_addr == ADDR_W'(OFS_SYSCFG) && host_wdata[1];

    // Classify accepted writes that reach the panel bus
    always_comb begin
        acc = ACC_NONE;
        if (wr_ok) begin
            case (host_addr)
                ADDR_W'(OFS_CMD):   acc = ACC_CMD;
                ADDR_W'(OFS_PARAM): acc = ACC_PARAM;
                ADDR_W'(OFS_DATA):  acc = ACC_DATA;
                ADDR_W'(OFS_RDACC): acc = ACC_RDREG;
                ADDR_W'(OFS_STACC): acc = ACC_STREG;
                default:            acc = ACC_NONE;
            endcase
        end
    end

    assign step = (acc == ACC_DATA) || (acc == ACC_RDREG) || (acc == ACC_STREG);

    // AND of all chip config registers for the start guard
    always_comb begin
        cfg_and = '1;
        for (int i = 0; i < N_CHIP; i++) cfg_and = cfg_and & cfg_q[i];
    end

    // Start guard: evaluated on the newly written control value
    assign start = wr_ok && host_addr == ADDR_W'(OFS_CTRL)
                && host_wdata[CB_GO] && host_wdata[CB_EN] && !host_wdata[CB_BYP]
                && rfb_mode && !busy && ((cfg_and & HW'(START_BLK)) == '0);

    // Local control, idle, line and sync-width registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= RST_CTRL;
            idle_q <= '0;
            line_q <= '0;
            vsw_q  <= '0;
            hsw_q  <= '0;
        end else if (wr_ok) begin
            if (soft_rst) begin
                ctrl_q <= RST_CTRL;
                line_q <= '0;
                vsw_q  <= '0;
                hsw_q  <= '0;
            end
            case (host_addr)
                ADDR_W'(OFS_SYSCFG): idle_q <= host_wdata[4:0] & MSK_IDLE;
                ADDR_W'(OFS_CTRL):   ctrl_q <= host_wdata[3:0];
                ADDR_W'(OFS_LINE):   line_q <= host_wdata[LINE_W-1:0];
                ADDR_W'(OFS_VSW):    vsw_q  <= host_wdata[SYNC_W-1:0];
                ADDR_W'(OFS_HSW):    hsw_q  <= host_wdata[SYNC_W-1:0];
                default: ;
            endcase
        end
    end

    // One storage bank per panel chip
    for (genvar g = 0; g < N_CHIP; g++) begin : g_bank
        rfb_chip_bank #(
            .AW   (ADDR_W),
            .DW   (HW),
            .BASE (ADDR_W'(OFS_BANK0) + ADDR_W'(g * BANK_STRIDE)),
            .N_DC (3)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .wr_en    (wr_ok),
            .addr     (host_addr),
            .wdata    (host_wdata),
            .rd_hit   (bank_hit[g]),
            .rd_data  (bank_rd[g]),
            .cfg_q    (cfg_q[g])
        );
    end

    rfb_bus_seq #(
        .BUS_W (BUS_W),
        .NCH   (N_CHIP)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .wdata     (host_wdata),
        .chip_sel  (ctrl_q[CB_CS0 +: N_CHIP]),
        .pnl_rdata (pnl_rdata),
        .pnl_data  (pnl_data),
        .pnl_rs    (pnl_rs),
        .pnl_cs    (pnl_cs),
        .pnl_rd    (pnl_rd),
        .hi_pend   (hi_pend),
        .rxbuf     (rxbuf)
    );

    rfb_xfer_ctl #(
        .PIX_W (PIX_W)
    ) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .ld         (wr_ok && host_addr == ADDR_W'(OFS_PIXCNT)),
        .ld_val     (host_wdata[PIX_W-1:0]),
        .step       (step),
        .start      (start),
        .cnt        (pix_cnt),
        .busy       (busy),
        .frame_done (frame_done)
    );

    // Host read multiplexer
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            ADDR_W'(OFS_SYSCFG):  host_rdata = HW'(idle_q);
            ADDR_W'(OFS_SYSSTAT): begin
                host_rdata[0]       = 1'b1;
                host_rdata[SB_BUSY] = busy;
            end
            ADDR_W'(OFS_CTRL):    host_rdata = HW'(ctrl_q);
            ADDR_W'(OFS_PIXCNT):  host_rdata = HW'(pix_cnt);
            ADDR_W'(OFS_LINE):    host_rdata = HW'(line_q);
            ADDR_W'(OFS_RDACC),
            ADDR_W'(OFS_STACC):   host_rdata = HW'(rxbuf);
            ADDR_W'(OFS_VSW):     host_rdata = HW'(vsw_q);
            ADDR_W'(OFS_HSW):     host_rdata = HW'(hsw_q);
            default: begin
                for (int i = 0; i < N_CHIP; i++) begin
                    if (bank_hit[i]) host_rdata = bank_rd[i];
                end
            end
        endcase
    end

endmodule

// File: rtl/rfb_bridge_chk.sv
// Protocol checker for rfb_bridge, attached with bind. It relates the host
// handshake, the panel strobes and the internal busy flag over time.
module rfb_bridge_chk
    import rfb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int HW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [HW-1:0]     host_wdata,
    input logic              host_ready,
    input logic              pnl_rs,
    input logic [N_CHIP-1:0] pnl_cs,
    input logic              pnl_rd,
    input logic              frame_done,
    input logic              busy
);

    AST_RD_SINGLE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        pnl_rd |-> $countones(pnl_cs) == 1); // R5

    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ready |=> host_ready); // R4

    AST_STALL_HALF_IS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ready |-> pnl_rs); // R4

    AST_CMD_SELECTS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_ready && host_addr == ADDR_W'(OFS_CMD)) |=> !pnl_rs); // R3

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!busy && $past(busy))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R8

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(host_wr && host_ready
                              && host_addr == ADDR_W'(OFS_CTRL) && host_wdata[CB_GO])); // R7

endmodule

bind rfb_bridge rfb_bridge_chk #(
    .ADDR_W (ADDR_W),
    .HW     (2 * BUS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_ready (host_ready),
    .pnl_rs     (pnl_rs),
    .pnl_cs     (pnl_cs),
    .pnl_rd     (pnl_rd),
    .frame_done (frame_done),
    .busy       (busy)
);

// File: tb/rfb_bridge_test.sv
// Self-checking bench: behavioural reference model updated on every rising
// edge, compared with the design on every falling edge, plus directed checks.
module rfb_bridge_test;

    // Offsets and constants taken from the requirements
    localparam logic [7:0] A_SYSCFG = 8'h04, A_SYSST = 8'h08, A_CTRL = 8'h0C,
                           A_PIX = 8'h10, A_LINE = 8'h14, A_CMD = 8'h18,
                           A_PAR = 8'h1C, A_DATA = 8'h20, A_RD = 8'h24,
                           A_ST = 8'h28, A_B0 = 8'h30, A_B1 = 8'h48,
                           A_VSW = 8'h60, A_HSW = 8'h64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [31:0] host_wdata = 32'h0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        rfb_mode = 1'b0;
    logic [15:0] pnl_data;
    logic        pnl_rs;
    logic [1:0]  pnl_cs;
    logic        pnl_rd;
    logic [15:0] pnl_rdata;
    logic        frame_done;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 0;

    always #10 clk = ~clk;

    // Panel chips: each returns its own fixed word when strobed
    assign pnl_rdata = pnl_cs[0] ? 16'hC0DE : (pnl_cs[1] ? 16'h51DE : 16'hDEAD);

    rfb_bridge uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
        .rfb_mode(rfb_mode), .pnl_data(pnl_data), .pnl_rs(pnl_rs), .pnl_cs(pnl_cs),
        .pnl_rd(pnl_rd), .pnl_rdata(pnl_rdata), .frame_done(frame_done)
    );

    // ---------------- reference model ----------------
    logic [3:0]  m_ctrl;
    logic [4:0]  m_idle;
    logic [31:0] m_line, m_vsw, m_hsw, m_cnt;
    logic [31:0] m_bank [2][6];
    logic        m_busy, m_cap, m_pend;
    logic [15:0] m_rx, m_hi;
    logic [1:0]  m_hcs;
    logic [15:0] e_data;
    logic        e_rs, e_rd, e_fd;
    logic [1:0]  e_cs;

    task automatic m_regs_reset();
        m_ctrl = 4'h2; m_line = 0; m_vsw = 0; m_hsw = 0; m_cnt = 0; m_busy = 0;
        for (int c = 0; c < 2; c++)
            for (int k = 0; k < 6; k++) m_bank[c][k] = (k == 0) ? 32'h0031_0000 : 32'h0;
    endtask

    task automatic m_step_cnt();
        if (m_busy && m_cnt == 1) begin m_busy = 0; e_fd = 1; end
        m_cnt = m_cnt - 1;
    endtask

    function automatic logic [31:0] m_mask(int k);
        case (k)
            0: return 32'h003F_1FFF;
            1: return 32'h3FFF_FFFF;
            2: return 32'h0FFF_FFFF;
            default: return 32'h0F1F_0F1F;
        endcase
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        logic [31:0] r;
        r = 0;
        case (a)
            A_SYSCFG: r = {27'h0, m_idle};
            A_SYSST:  r = {23'h0, m_busy, 8'h01};
            A_CTRL:   r = {28'h0, m_ctrl};
            A_PIX:    r = m_cnt;
            A_LINE:   r = m_line;
            A_RD, A_ST: r = {16'h0, m_rx};
            A_VSW:    r = m_vsw;
            A_HSW:    r = m_hsw;
            default:
                for (int c = 0; c < 2; c++)
                    for (int k = 0; k < 6; k++)
                        if (a == ((c == 0 ? A_B0 : A_B1) + 8'(4 * k))) r = m_bank[c][k];
        endcase
        return r;
    endfunction

    // Model update on each rising edge using the stable inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_regs_reset();
            m_idle = 0; m_rx = 0; m_cap = 0; m_pend = 0; m_hi = 0; m_hcs = 0;
            e_data = 0; e_rs = 0; e_rd = 0; e_fd = 0; e_cs = 0;
        end else begin
            logic [1:0] sel;
            e_cs = 0; e_rd = 0; e_fd = 0;
            if (m_cap) begin m_rx = pnl_rdata; m_cap = 0; end
            if (m_pend) begin
                e_data = m_hi; e_rs = 1; e_cs = m_hcs; m_pend = 0;
            end else if (host_wr) begin
                case (host_addr)
                    A_SYSCFG: begin
                        if (host_wdata[1]) m_regs_reset();
                        m_idle = host_wdata[4:0] & 5'h19;
                    end
                    A_CTRL: begin
                        if (host_wdata[4] && host_wdata[0] && !host_wdata[1] && rfb_mode
                            && !m_busy && ((m_bank[0][0] & m_bank[1][0] & 32'hC) == 0))
                            m_busy = 1;
                        m_ctrl = host_wdata[3:0];
                    end
                    A_PIX:  m_cnt = host_wdata;
                    A_LINE: m_line = host_wdata & 32'h7FF;
                    A_VSW:  m_vsw = host_wdata & 32'hFFFF;
                    A_HSW:  m_hsw = host_wdata & 32'hFFFF;
                    A_CMD, A_PAR: begin
                        e_data = host_wdata[15:0]; e_rs = (host_addr == A_PAR);
                        e_cs = m_ctrl[3:2];
                    end
                    A_DATA: begin
                        e_data = host_wdata[15:0]; e_rs = 1; e_cs = m_ctrl[3:2];
                        m_hi = host_wdata[31:16]; m_hcs = m_ctrl[3:2]; m_pend = 1;
                        m_step_cnt();
                    end
                    A_RD, A_ST: begin
                        sel = m_ctrl[2] ? 2'b01 : (m_ctrl[3] ? 2'b10 : 2'b00);
                        e_rs = (host_addr == A_RD); e_cs = sel;
                        e_rd = (sel != 0); m_cap = (sel != 0);
                        m_step_cnt();
                    end
                    default:
                        for (int c = 0; c < 2; c++)
                            for (int k = 0; k < 6; k++)
                                if (host_addr == ((c == 0 ? A_B0 : A_B1) + 8'(4 * k)))
                                    m_bank[c][k] = host_wdata & m_mask(k);
                endcase
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2", "rdata", host_rdata, m_read(host_addr));
            chk("R4", "ready", {31'h0, host_ready}, {31'h0, !m_pend});
            chk("R3", "pnl_data", {16'h0, pnl_data}, {16'h0, e_data});
            chk("R3", "pnl_rs", {31'h0, pnl_rs}, {31'h0, e_rs});
            chk("R3", "pnl_cs", {30'h0, pnl_cs}, {30'h0, e_cs});
            chk("R5", "pnl_rd", {31'h0, pnl_rd}, {31'h0, e_rd});
            chk("R8", "frame_done", {31'h0, frame_done}, {31'h0, e_fd});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(bit w, logic [7:0] a, logic [31:0] d);
        @(negedge clk); #2;
        host_wr = w; host_addr = a; host_wdata = d;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); #2;
        while (!host_ready) begin
            host_wr = 0;
            @(negedge clk); #2;
        end
        host_wr = 1; host_addr = a; host_wdata = d;
    endtask

    task automatic peek(logic [7:0] a, logic [31:0] exp, string req);
        drive(0, a, 32'h0);
        #1;
        chk(req, $sformatf("reg %h", a), host_rdata, exp);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1; cmp_on = 1;

        // R1: reset values
        peek(A_CTRL, 32'h2, "R1");
        peek(A_B0, 32'h0031_0000, "R1");
        peek(A_B1, 32'h0031_0000, "R1");
        peek(A_SYSST, 32'h1, "R1");
        peek(A_PIX, 32'h0, "R1");
        peek(A_LINE, 32'h0, "R1");
        peek(A_HSW, 32'h0, "R1");
        peek(A_B1 + 8'h14, 32'h0, "R1");

        // R2: write masks
        wr(A_CTRL, 32'hFFFF_FFFF);  peek(A_CTRL, 32'hF, "R2");
        wr(A_B0, 32'hFFFF_FFFF);    peek(A_B0, 32'h003F_1FFF, "R2");
        wr(A_B0 + 8'h4, 32'hFFFF_FFFF); peek(A_B0 + 8'h4, 32'h3FFF_FFFF, "R2");
        wr(A_B1 + 8'h8, 32'hFFFF_FFFF); peek(A_B1 + 8'h8, 32'h0FFF_FFFF, "R2");
        wr(A_B1 + 8'h10, 32'hFFFF_FFFF); peek(A_B1 + 8'h10, 32'h0F1F_0F1F, "R2");
        wr(A_LINE, 32'hFFFF_FFFF);  peek(A_LINE, 32'h7FF, "R2");
        wr(A_VSW, 32'hFFFF_FFFF);   peek(A_VSW, 32'hFFFF, "R2");
        wr(A_SYSCFG, 32'hFFFF_FFFD); peek(A_SYSCFG, 32'h19, "R2");

        // R9: soft reset restores defaults and stores idle bits
        wr(A_SYSCFG, 32'h0000_000B);
        peek(A_SYSCFG, 32'h9, "R9");
        peek(A_CTRL, 32'h2, "R9");
        peek(A_B0, 32'h0031_0000, "R9");
        peek(A_LINE, 32'h0, "R9");

        // R3: command to chip 0, parameter to both chips
        wr(A_CTRL, 32'h4);
        wr(A_CMD, 32'h1234_ABCD);
        drive(0, A_CTRL, 0); #1;
        chk("R3", "cmd cs", {30'h0, pnl_cs}, 32'h1);
        chk("R3", "cmd rs", {31'h0, pnl_rs}, 32'h0);
        chk("R3", "cmd data", {16'h0, pnl_data}, 32'hABCD);
        wr(A_CTRL, 32'hC);
        wr(A_PAR, 32'h0000_0042);
        drive(0, A_CTRL, 0); #1;
        chk("R3", "param cs", {30'h0, pnl_cs}, 32'h3);
        chk("R3", "param rs", {31'h0, pnl_rs}, 32'h1);

        // R4: split data write; a write during the stall is dropped
        drive(1, A_DATA, 32'hBEEF_5AA5);
        drive(1, A_CMD, 32'h0000_7777); #1;
        chk("R4", "low half", {16'h0, pnl_data}, 32'h5AA5);
        chk("R4", "stall", {31'h0, host_ready}, 32'h0);
        drive(0, A_CTRL, 0); #1;
        chk("R4", "high half", {16'h0, pnl_data}, 32'hBEEF);
        chk("R4", "high cs", {30'h0, pnl_cs}, 32'h3);
        chk("R4", "ready back", {31'h0, host_ready}, 32'h1);
        drive(0, A_CTRL, 0); #1;
        chk("R4", "stalled cmd dropped", {14'h0, pnl_cs, pnl_data}, {14'h0, 2'b00, 16'hBEEF});

        // R5: read priority to chip 0, then status read from chip 1
        wr(A_RD, 32'h0);
        drive(0, A_CTRL, 0); #1;
        chk("R5", "read cs", {30'h0, pnl_cs}, 32'h1);
        chk("R5", "read rd", {31'h0, pnl_rd}, 32'h1);
        chk("R5", "read rs", {31'h0, pnl_rs}, 32'h1);
        peek(A_RD, 32'hC0DE, "R5");
        wr(A_CTRL, 32'h8);
        wr(A_ST, 32'h0);
        drive(0, A_CTRL, 0); #1;
        chk("R5", "status cs", {30'h0, pnl_cs}, 32'h2);
        chk("R5", "status rs", {31'h0, pnl_rs}, 32'h0);
        peek(A_ST, 32'h51DE, "R5");

        // R6: countdown by every counting access, then wrap from zero
        wr(A_CTRL, 32'h4);
        wr(A_PIX, 32'd3);
        wr(A_DATA, 32'h1111_2222); peek(A_PIX, 32'd2, "R6");
        wr(A_ST, 32'h0);           peek(A_PIX, 32'd1, "R6");
        wr(A_RD, 32'h0);           peek(A_PIX, 32'd0, "R6");
        chk("R8", "no pulse when idle", {31'h0, frame_done}, 32'h0);
        wr(A_RD, 32'h0);           peek(A_PIX, 32'hFFFF_FFFF, "R6");

        // R7: each start guard alone blocks the start
        wr(A_PIX, 32'd2);
        wr(A_CTRL, 32'h15);        peek(A_SYSST, 32'h1, "R7");
        rfb_mode = 1;
        wr(A_CTRL, 32'h17);        peek(A_SYSST, 32'h1, "R7");
        wr(A_CTRL, 32'h14);        peek(A_SYSST, 32'h1, "R7");
        wr(A_B0, 32'h4);
        wr(A_B1, 32'h4);
        wr(A_CTRL, 32'h15);        peek(A_SYSST, 32'h1, "R7");
        wr(A_B1, 32'h0031_0000);
        wr(A_CTRL, 32'h15);        peek(A_SYSST, 32'h101, "R7");

        // R8: completion pulse when the count reaches zero while busy
        wr(A_DATA, 32'hAAAA_5555); peek(A_SYSST, 32'h101, "R8");
        wr(A_DATA, 32'hCCCC_3333);
        drive(0, A_CTRL, 0); #1;
        chk("R8", "frame_done", {31'h0, frame_done}, 32'h1);
        peek(A_SYSST, 32'h1, "R8");
        chk("R8", "pulse width", {31'h0, frame_done}, 32'h0);

        // R10: no chip selected: no strobes, counting continues
        wr(A_CTRL, 32'h1);
        wr(A_PIX, 32'd5);
        wr(A_CMD, 32'h0000_0101);
        wr(A_DATA, 32'h0202_0303);
        wr(A_RD, 32'h0);
        drive(0, A_CTRL, 0); #1;
        chk("R10", "no cs", {30'h0, pnl_cs}, 32'h0);
        chk("R10", "no rd", {31'h0, pnl_rd}, 32'h0);
        peek(A_PIX, 32'd3, "R10");

        drive(0, A_CTRL, 0);
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule